// File: doc/BRIEF.md
# Console UART Status and Interrupt Register

This block holds the status word and the interrupt logic of a console serial port. The receive and transmit datapaths report events to it: a byte being written into the receive buffer, whether that buffer still holds unread data, a received byte matching the configured flow-control character, the transmit holding register handing its byte to the shifter, and the shifter being empty. A CPU reaches the block through a word-indexed register bus with separate read and write strobes. The locations are the status word, the interrupt-enable word, the transmit-data slot and a transmit-mode field.

Two error-style flags are sticky. An overrun happens when a byte arrives while the buffer is still full. A control-character match records that the configured character arrived. Software clears either flag by writing a one to its bit. The holding-empty flag works differently: writing transmit data clears it, and the datapath sets it again once it takes the byte. It interrupts only when the mode field selects interrupt-driven transmit. All enabled sources are ORed into one registered interrupt request. A control-character match only raises the flag. It never stalls the transmit or receive paths.

Top module: `con_uart_status`

## Requirements
- R1: After reset, the interrupt is 0, the enable word and the mode field read 0, and the status word reads bit 18 = 1, bit 17 = `tx_sh_empty`, bit 11 = `rx_idle`, with every other bit 0.
- R2: Status bit 4 (overrun) is set when `rx_fill` is high while `rx_full` is high. `rx_fill` with `rx_full` low leaves it unchanged.
- R3: Status bit 5 (control character) is set when `rx_ctl_hit` is high. The flag has no effect on `tx_load` or `tx_byte`.
- R4: Writing the status location (index 0) with a 1 in bit 4 or bit 5 clears that flag. A 0 in that bit leaves the flag unchanged.
- R5: When a set event and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R6: Bits 4 and 5 request an interrupt only while the enable word (index 1) holds a 1 at the same bit position.
- R7: Status bit 17 is 1 exactly when the holding-empty flag is 1 and `tx_sh_empty` is 1. Status bit 18 reflects the holding register alone, whatever the shifter state.
- R8: A write to the transmit-data location (index 2) drives `tx_load` high and `tx_byte` with the low data bits in that same cycle, and it clears bit 18. A `tx_drain` pulse sets bit 18 again. If a data write and `tx_drain` arrive in the same cycle, the write wins.
- R9: Bit 18 raises an interrupt only when enable bit 18 is 1 and the mode field (index 3, bits 1:0) equals 2'b01.
- R10: Status bit 11 follows `rx_idle`. Status bits 10:6, 16:12 and 31:19 read 0. In the enable word only bits 4, 5 and 18 store and read back. Unmapped locations read 0.
- R11: `irq` is registered. It changes on the clock edge after the edge that changed a status flag, an enable bit or the mode field.
- R12: `bus_rdata` loads the addressed word on the edge where `bus_rd` is sampled high, and it holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word index: 0 status, 1 enable, 2 transmit data, 3 mode |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_fill | input | 1 | A received byte is being written into the receive buffer |
| rx_full | input | 1 | The receive buffer holds unread valid data |
| rx_ctl_hit | input | 1 | The received byte matches the control character |
| rx_idle | input | 1 | The receive buffer is inactive |
| tx_drain | input | 1 | The holding register has passed its byte to the shifter |
| tx_sh_empty | input | 1 | The transmit shift register is empty |
| tx_load | output | 1 | Transmit data write strobe to the holding register |
| tx_byte | output | TXD_W | Transmit data to the holding register |
| irq | output | 1 | Interrupt request |

## Verification
Flag updates take effect on the edge that samples the event or the write. `irq` follows one edge later, and `bus_rdata` shows the word as it stood before the edge that sampled `bus_rd`. `tx_load` and `tx_byte` are combinational in the write cycle. The bench drives every input at the falling edge. Directly after each enable, mode or flag change it checks that `irq` has not yet moved, and one cycle later it checks the new value. Read expectations go into a queue, and a monitor compares each one against `bus_rdata` just after the sampling edge.

// File: rtl/ust_pkg.sv
package ust_pkg;
   localparam int OVR_BIT  = 4;
   localparam int CCD_BIT  = 5;
   localparam int RXI_BIT  = 11;
   localparam int TXI_BIT  = 17;
   localparam int THE_BIT  = 18;
   localparam int STAT_MIN_W = THE_BIT + 1;
   localparam int MODE_W   = 2;

   typedef enum logic [MODE_W-1:0] {
      TXM_OFF   = 2'b00,
      TXM_IRQ   = 2'b01,
      TXM_ALT_A = 2'b10,
      TXM_ALT_B = 2'b11
   } txmode_e;
endpackage

// File: rtl/ust_w1c_flag.sv
module ust_w1c_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_pri
         always_comb begin
            if (set_i)      nxt = 1'b1;
            else if (clr_i) nxt = 1'b0;
            else            nxt = flag_o;
         end
      end else begin : g_clr_pri
         always_comb begin
            if (clr_i)      nxt = 1'b0;
            else if (set_i) nxt = 1'b1;
            else            nxt = flag_o;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= nxt;
   end
endmodule

// File: rtl/ust_txstat.sv
module ust_txstat (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic drain_i,
   input  logic sh_empty_i,
   output logic hold_empty_o,
   output logic tx_idle_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_empty_o <= 1'b1;
      else if (load_i)  hold_empty_o <= 1'b0;
      else if (drain_i) hold_empty_o <= 1'b1;
   end

   assign tx_idle_o = hold_empty_o & sh_empty_i;
endmodule

// File: rtl/ust_regif.sv
module ust_regif
   import ust_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32,
   parameter int STAT_IDX = 0,
   parameter int IEN_IDX  = 1,
   parameter int TXD_IDX  = 2,
   parameter int MODE_IDX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] stat_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] ien_o,
   output txmode_e           mode_o,
   output logic              stat_wr_o,
   output logic              txd_wr_o
);
   localparam logic [DATA_W-1:0] IEN_MASK =
      DATA_W'((64'd1 << OVR_BIT) | (64'd1 << CCD_BIT) | (64'd1 << THE_BIT));

   logic hit_stat, hit_ien, hit_txd, hit_mode;
   assign hit_stat = (addr_i == ADDR_W'(STAT_IDX));
   assign hit_ien  = (addr_i == ADDR_W'(IEN_IDX));
   assign hit_txd  = (addr_i == ADDR_W'(TXD_IDX));
   assign hit_mode = (addr_i == ADDR_W'(MODE_IDX));

   assign stat_wr_o = wr_i & hit_stat;
   assign txd_wr_o  = wr_i & hit_txd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_o  <= '0;
         mode_o <= TXM_OFF;
      end else if (wr_i) begin
         if (hit_ien)  ien_o  <= wdata_i & IEN_MASK;
         if (hit_mode) mode_o <= txmode_e'(wdata_i[MODE_W-1:0]);
      end
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (hit_stat)      rd_mux = stat_i;
      else if (hit_ien)  rd_mux = ien_o;
      else if (hit_mode) rd_mux[MODE_W-1:0] = mode_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= rd_mux;
   end
endmodule

// File: rtl/con_uart_status.sv
module con_uart_status
   import ust_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32,
   parameter int TXD_W    = 8,
   parameter bit IRQ_REG  = 1'b1,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_fill,
   input  logic              rx_full,
   input  logic              rx_ctl_hit,
   input  logic              rx_idle,
   input  logic              tx_drain,
   input  logic              tx_sh_empty,
   output logic              tx_load,
   output logic [TXD_W-1:0]  tx_byte,
   output logic              irq
);
   localparam int STAT_IDX = 0;
   localparam int IEN_IDX  = 1;
   localparam int TXD_IDX  = 2;
   localparam int MODE_IDX = 3;
   localparam int NSTICKY  = 2;

   generate
      if (DATA_W < STAT_MIN_W) begin : g_bad_data_w
         $error("DATA_W too narrow for status word");
      end
      if (TXD_W > DATA_W || TXD_W < 1) begin : g_bad_txd_w
         $error("TXD_W must be 1..DATA_W");
      end
      if ((1 << ADDR_W) <= MODE_IDX) begin : g_bad_addr_w
         $error("ADDR_W too narrow for register map");
      end
   endgenerate

   logic [DATA_W-1:0] stat_word, ien;
   txmode_e           mode;
   logic              stat_wr, txd_wr;

   ust_regif #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_IDX(STAT_IDX),
      .IEN_IDX(IEN_IDX), .TXD_IDX(TXD_IDX), .MODE_IDX(MODE_IDX)
   ) u_regif (
      .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
      .rd_i(bus_rd), .wdata_i(bus_wdata), .stat_i(stat_word),
      .rdata_o(bus_rdata), .ien_o(ien), .mode_o(mode),
      .stat_wr_o(stat_wr), .txd_wr_o(txd_wr)
   );

   // sticky receive flags: index 0 overrun, index 1 control character
   logic [NSTICKY-1:0] st_set, st_clr, st_q;
   assign st_set = {rx_ctl_hit, rx_fill & rx_full};
   assign st_clr = {stat_wr & bus_wdata[CCD_BIT], stat_wr & bus_wdata[OVR_BIT]};

   for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
      ust_w1c_flag #(.SET_WINS(SET_WINS)) u_flag (
         .clk(clk), .rst_n(rst_n), .set_i(st_set[i]),
         .clr_i(st_clr[i]), .flag_o(st_q[i])
      );
   end

   logic hold_empty, tx_idle;
   ust_txstat u_txstat (
      .clk(clk), .rst_n(rst_n), .load_i(txd_wr), .drain_i(tx_drain),
      .sh_empty_i(tx_sh_empty), .hold_empty_o(hold_empty), .tx_idle_o(tx_idle)
   );

   assign tx_load = txd_wr;
   assign tx_byte = bus_wdata[TXD_W-1:0];

   always_comb begin
      stat_word          = '0;
      stat_word[OVR_BIT] = st_q[0];
      stat_word[CCD_BIT] = st_q[1];
      stat_word[RXI_BIT] = rx_idle;
      stat_word[TXI_BIT] = tx_idle;
      stat_word[THE_BIT] = hold_empty;
   end

   logic irq_any;
   assign irq_any = (stat_word[OVR_BIT] & ien[OVR_BIT])
                  | (stat_word[CCD_BIT] & ien[CCD_BIT])
                  | (stat_word[THE_BIT] & ien[THE_BIT] & (mode == TXM_IRQ));

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_any;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_any;
      end
   endgenerate

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata, ien};
endmodule

// File: rtl/ust_chk.sv
module ust_chk
   import ust_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] stat_word,
   input logic [DATA_W-1:0] ien,
   input txmode_e           mode,
   input logic              stat_wr,
   input logic              txd_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              rx_fill,
   input logic              rx_full,
   input logic              rx_ctl_hit,
   input logic              tx_drain,
   input logic              irq
);
   localparam logic [DATA_W-1:0] RSV_MASK = ~DATA_W'(
      (64'd1 << OVR_BIT) | (64'd1 << CCD_BIT) | (64'd1 << RXI_BIT) |
      (64'd1 << TXI_BIT) | (64'd1 << THE_BIT));

   a_r2_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fill && rx_full) |=> stat_word[OVR_BIT]);

   a_r3_ccd_set: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ctl_hit |=> stat_word[CCD_BIT]);

   a_r4_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && bus_wdata[OVR_BIT] && !(rx_fill && rx_full)) |=> !stat_word[OVR_BIT]);

   a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_word[CCD_BIT] && !(stat_wr && bus_wdata[CCD_BIT])) |=> stat_word[CCD_BIT]);

   a_r7_txi_needs_the: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[TXI_BIT] |-> stat_word[THE_BIT]);

   a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      txd_wr |=> !stat_word[THE_BIT]);

   a_r8_drain_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_drain && !txd_wr) |=> stat_word[THE_BIT]);

   a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_word & RSV_MASK) == '0);

   generate
      if (IRQ_REG) begin : g_irq_props
         a_r9_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (mode != TXM_IRQ && !(stat_word[OVR_BIT] && ien[OVR_BIT])
             && !(stat_word[CCD_BIT] && ien[CCD_BIT])) |=> !irq);

         a_r11_irq_late: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_word[THE_BIT] && ien[THE_BIT] && mode == TXM_IRQ) |=> irq);

         a_r6_enabled_src: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_word[OVR_BIT] && ien[OVR_BIT]) |=> irq);
      end
   endgenerate
endmodule

bind con_uart_status ust_chk #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .stat_word(stat_word), .ien(ien), .mode(mode),
   .stat_wr(stat_wr), .txd_wr(txd_wr), .bus_wdata(bus_wdata),
   .rx_fill(rx_fill), .rx_full(rx_full), .rx_ctl_hit(rx_ctl_hit),
   .tx_drain(tx_drain), .irq(irq)
);

// File: tb/tb_con_uart_status.sv
module tb_con_uart_status;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam int TXD_W  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic rx_fill = 1'b0, rx_full = 1'b0, rx_ctl_hit = 1'b0, rx_idle = 1'b1;
   logic tx_drain = 1'b0, tx_sh_empty = 1'b1;
   logic tx_load, irq;
   logic [TXD_W-1:0] tx_byte;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   con_uart_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TXD_W(TXD_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_fill(rx_fill), .rx_full(rx_full), .rx_ctl_hit(rx_ctl_hit),
      .rx_idle(rx_idle), .tx_drain(tx_drain), .tx_sh_empty(tx_sh_empty),
      .tx_load(tx_load), .tx_byte(tx_byte), .irq(irq)
   );

   typedef struct {
      logic [DATA_W-1:0] exp;
      string             tag;
   } rd_item_t;
   rd_item_t rdq[$];

   localparam logic [DATA_W-1:0] S_RST = 32'h0006_0800;

   task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                      input logic [DATA_W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // monitor: compares registered read data just after the sampling edge
   always @(posedge clk) begin
      if (bus_rd) begin
         #1;
         if (rdq.size() == 0) begin
            total++; bad++;
            $display("FAIL R12 unexpected read act=%h exp=none", bus_rdata);
         end else begin
            rd_item_t it;
            it = rdq.pop_front();
            chk(it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic rd(input int idx, input logic [DATA_W-1:0] exp, input string tag);
      rd_item_t it;
      it.exp = exp; it.tag = tag;
      rdq.push_back(it);
      bus_addr = ADDR_W'(idx); bus_rd = 1'b1;
      step();
      bus_rd = 1'b0;
   endtask

   task automatic wr(input int idx, input logic [DATA_W-1:0] d);
      bus_addr = ADDR_W'(idx); bus_wdata = d; bus_wr = 1'b1;
      step();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);
      rd(0, S_RST, "R1 status reset");
      rd(1, 32'd0, "R1 enable reset");
      rd(3, 32'd0, "R1 mode reset");

      // R2 fill without full: no overrun
      rx_fill = 1'b1; step(); rx_fill = 1'b0;
      rd(0, S_RST, "R2 no overrun when empty");
      rx_fill = 1'b1; rx_full = 1'b1; step(); rx_fill = 1'b0; rx_full = 1'b0;
      step();
      chk("R6 overrun not enabled", {31'd0, irq}, 32'd0);
      rd(0, S_RST | 32'h10, "R2 overrun set");

      // R4 write 0 keeps, write 1 clears
      wr(0, 32'hFFFF_FFEF);
      rd(0, S_RST | 32'h10, "R4 zero keeps flag");
      wr(0, 32'h0000_0010);
      rd(0, S_RST, "R4 one clears flag");

      // R3 control character, tx write unaffected; R8 load clears holding-empty
      rx_ctl_hit = 1'b1; step(); rx_ctl_hit = 1'b0;
      bus_addr = ADDR_W'(2); bus_wdata = 32'h0000_01A5; bus_wr = 1'b1;
      #1;
      chk("R3 R8 tx_load with flag set", {31'd0, tx_load}, 32'd1);
      chk("R8 tx_byte", {24'd0, tx_byte}, 32'hA5);
      step(); bus_wr = 1'b0; bus_wdata = '0;
      #1;
      chk("R8 tx_load drops", {31'd0, tx_load}, 32'd0);
      rd(0, 32'h0000_0820, "R8 holding full clears 18 and 17");

      // R7 holding empty without idle shifter
      tx_sh_empty = 1'b0;
      tx_drain = 1'b1; step(); tx_drain = 1'b0;
      rd(0, 32'h0004_0820, "R7 bit18 ignores shifter");
      tx_sh_empty = 1'b1;
      rd(0, 32'h0006_0820, "R7 both empty gives idle");

      // R10 enable mask; R6 enable ccd; R11 delay
      wr(1, 32'hFFFF_FFFF);
      chk("R11 irq not yet", {31'd0, irq}, 32'd0);
      step();
      chk("R6 ccd enabled irq", {31'd0, irq}, 32'd1);
      rd(1, 32'h0004_0030, "R10 enable readback mask");
      wr(0, 32'h0000_0020);
      chk("R11 irq holds one cycle", {31'd0, irq}, 32'd1);
      step();
      chk("R4 irq drops after clear", {31'd0, irq}, 32'd0);

      // R9 mode gating of holding-empty
      wr(3, 32'h0000_0001);
      chk("R11 mode irq not yet", {31'd0, irq}, 32'd0);
      step();
      chk("R9 mode 01 irq", {31'd0, irq}, 32'd1);
      rd(3, 32'h1, "R9 mode readback");
      wr(3, 32'h0000_0002);
      step();
      chk("R9 mode 10 no irq", {31'd0, irq}, 32'd0);
      wr(3, 32'h0000_0001);
      step();
      chk("R9 mode 01 again", {31'd0, irq}, 32'd1);
      wr(2, 32'h0000_0033);
      step();
      chk("R9 write clears holding irq", {31'd0, irq}, 32'd0);
      // R8 write and drain same cycle: write wins
      bus_addr = ADDR_W'(2); bus_wdata = 32'h44; bus_wr = 1'b1; tx_drain = 1'b1;
      step(); bus_wr = 1'b0; tx_drain = 1'b0;
      rd(0, 32'h0000_0800, "R8 write beats drain");
      tx_drain = 1'b1; step(); tx_drain = 1'b0;
      step();
      chk("R9 drain raises irq", {31'd0, irq}, 32'd1);
      wr(3, 32'h0);
      step();
      chk("R9 mode off drops irq", {31'd0, irq}, 32'd0);

      // R5 set wins over same-cycle clear
      rx_fill = 1'b1; rx_full = 1'b1;
      bus_addr = ADDR_W'(0); bus_wdata = 32'h10; bus_wr = 1'b1;
      step();
      rx_fill = 1'b0; rx_full = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      step();
      chk("R5 R6 overrun irq", {31'd0, irq}, 32'd1);
      rd(0, S_RST | 32'h10, "R5 set wins");
      wr(0, 32'h10);
      step();
      chk("R4 overrun irq cleared", {31'd0, irq}, 32'd0);

      // R10 rx idle mirror and unmapped read
      rx_idle = 1'b0;
      rd(0, 32'h0006_0000, "R10 rx idle low");
      rd(7, 32'h0, "R10 unmapped reads zero");
      rd(2, 32'h0, "R10 tx data reads zero");
      rx_idle = 1'b1;

      // R12 read data holds without a read
      rd(0, S_RST, "R12 fresh read");
      rx_ctl_hit = 1'b1; step(); rx_ctl_hit = 1'b0;
      step();
      chk("R12 rdata holds", bus_rdata, S_RST);
      rd(0, S_RST | 32'h20, "R12 new read sees flag");

      step(); step();
      if (rdq.size() != 0) begin
         total++; bad++;
         $display("FAIL R12 pending reads act=%0d exp=0", rdq.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule